// File: doc/BRIEF.md
# Run-time partitioned SIMD adder

This block adds two 16-bit words with a carry chain that can be cut at bits 4, 8 and 12 while the chip runs. The word can be one 16-bit lane, two 8-bit lanes or four 4-bit lanes. Each lane adds its own slice of the operands and wraps around inside that slice, so a carry never crosses into the lane above.

Two mode inputs pick the lane layout. The nibble input cuts the chain at all three points. The byte input cuts it only at bit 8. With both inputs low the word is a single lane, and the nibble setting wins when both are high. The block is purely combinational, so the sum and the boundary mask follow the inputs in the same cycle. A companion mask output marks each active lane boundary with a cleared bit, and downstream lane-aware logic can read it.

Top module: `simd_split_adder`

## Requirements
- R1: With both mode inputs low, `sum_out` equals (`a_in` + `b_in`) mod 2^16, for example 0xFFFF + 0x0001 gives 0x0000.
- R2: With `lane_byte` high and `lane_nib` low, bits [7:0] and [15:8] are two independent 8-bit sums that wrap, for example 0xFFFF + 0xFFFF gives 0xFEFE and 0x00FF + 0x0001 gives 0x0000.
- R3: With `lane_nib` high, each of bits [3:0], [7:4], [11:8] and [15:12] is an independent 4-bit sum that wraps, for example 0x0FFF + 0x0111 gives 0x0000.
- R4: With both mode inputs high, the block behaves exactly as it does with only `lane_nib` high, for both outputs.
- R5: With both mode inputs low, `cut_mask` is 0xFFFF. Every bit of `cut_mask` whose index is not 4, 8 or 12 is always 1.
- R6: With only `lane_byte` high, `cut_mask` is 0xFEFF, which means only bit 8 is cleared.
- R7: With `lane_nib` high, `cut_mask` is 0xEEEF, which means bits 4, 8 and 12 are cleared.
- R8: Both outputs follow an input change within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_nib | input | 1 | Nibble lane mode: cut the carry at bits 4, 8 and 12 |
| lane_byte | input | 1 | Byte lane mode: cut the carry at bit 8 |
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| sum_out | output | 16 | Lane-wise wrapped sum |
| cut_mask | output | 16 | All ones except a 0 at each active cut position |

## Verification
The checker evaluates its immediate assertions whenever an input or output changes. It assumes that every input carries a defined 0/1 value and that the operands and modes settle together before the outputs are judged. The bench drives the mode pins and both operands from one process, in a single time step just after a clock edge. It never leaves an input unknown, so each assertion sees a consistent input set. The mid-cycle changes for R8 follow the same rule, with every input updated at once.

// File: rtl/simd_split_adder.sv
`timescale 1ns/1ps
module simd_split_adder #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              lane_nib,
  input  logic              lane_byte,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] sum_out,
  output logic [DATA_W-1:0] cut_mask
);
  localparam int NSEG = DATA_W / NIB_W;
  localparam int NCUT = NSEG - 1;

  logic [NCUT-1:0] cut;
  logic [NSEG-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_low
      assign cut_mask[0] = 1'b1;
    end else begin : g_edge
      assign cut_mask[g*NIB_W] = ~cut[g-1];
    end
    assign cut_mask[g*NIB_W+1 +: NIB_W-1] = '1;

    if (g < NCUT) begin : g_mid
      localparam int POS = (g + 1) * NIB_W;
      logic co;
      if (POS % BYTE_W == 0) begin : g_bpt
        assign cut[g] = lane_nib | lane_byte;
      end else begin : g_npt
        assign cut[g] = lane_nib;
      end
      assign {co, sum_out[g*NIB_W +: NIB_W]} = {1'b0, a_in[g*NIB_W +: NIB_W]}
                                             + {1'b0, b_in[g*NIB_W +: NIB_W]}
                                             + {{NIB_W{1'b0}}, cy[g]};
      assign cy[g+1] = co & ~cut[g];
    end else begin : g_top
      assign sum_out[g*NIB_W +: NIB_W] = a_in[g*NIB_W +: NIB_W]
                                       + b_in[g*NIB_W +: NIB_W]
                                       + {{(NIB_W-1){1'b0}}, cy[g]};
    end
  end
endmodule

// File: rtl/simd_split_adder_chk.sv
`timescale 1ns/1ps
module simd_split_adder_chk #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input logic              lane_nib,
  input logic              lane_byte,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic [DATA_W-1:0] sum_out,
  input logic [DATA_W-1:0] cut_mask
);
  localparam int NSEG  = DATA_W / NIB_W;
  localparam int NBSEG = DATA_W / BYTE_W;

  always_comb begin
    if (!lane_nib && !lane_byte) begin
      a_r1_full_word: assert (sum_out == a_in + b_in)
        else $error("R1 full-width sum mismatch");
    end
    if (lane_byte && !lane_nib) begin
      for (int i = 0; i < NBSEG; i++) begin
        a_r2_byte_lane: assert (sum_out[i*BYTE_W +: BYTE_W] ==
                                BYTE_W'(a_in[i*BYTE_W +: BYTE_W] + b_in[i*BYTE_W +: BYTE_W]))
          else $error("R2 byte lane %0d mismatch", i);
      end
    end
    if (lane_nib) begin
      for (int i = 0; i < NSEG; i++) begin
        a_r3_nib_lane: assert (sum_out[i*NIB_W +: NIB_W] ==
                               NIB_W'(a_in[i*NIB_W +: NIB_W] + b_in[i*NIB_W +: NIB_W]))
          else $error("R3 nibble lane %0d mismatch", i);
      end
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (i % NIB_W != 0) begin
        a_r5_inner_ones: assert (cut_mask[i])
          else $error("R5 mask bit %0d cleared inside a lane", i);
      end
    end
    a_r7_cut_count: assert ($countones(~cut_mask) ==
                            (lane_nib ? NSEG - 1 : (lane_byte ? NBSEG - 1 : 0)))
      else $error("R7 wrong number of cut positions");
  end
endmodule

bind simd_split_adder simd_split_adder_chk #(
  .DATA_W(DATA_W), .NIB_W(NIB_W), .BYTE_W(BYTE_W)
) u_chk (
  .lane_nib(lane_nib), .lane_byte(lane_byte), .a_in(a_in), .b_in(b_in),
  .sum_out(sum_out), .cut_mask(cut_mask)
);

// File: tb/simd_split_adder_tb.sv
`timescale 1ns/1ps
module simd_split_adder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lane_nib = 1'b0, lane_byte = 1'b0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] sum_out, cut_mask;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_split_adder u_dut (
    .lane_nib(lane_nib), .lane_byte(lane_byte), .a_in(a_in), .b_in(b_in),
    .sum_out(sum_out), .cut_mask(cut_mask)
  );

  function automatic logic [15:0] ref_sum(input logic [15:0] a, b, input logic nb, by);
    int w = nb ? 4 : (by ? 8 : 16);
    int m = (1 << w) - 1;
    logic [15:0] r = '0;
    for (int s = 0; s < 16; s += w) begin
      int x = ((int'(a) >> s) & m) + ((int'(b) >> s) & m);
      r = r | 16'((x & m) << s);
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_mask(input logic nb, by);
    logic [15:0] r = 16'hFFFF;
    if (nb) begin r[4] = 1'b0; r[8] = 1'b0; r[12] = 1'b0; end
    else if (by) r[8] = 1'b0;
    return r;
  endfunction

  task automatic compare(input string tag);
    logic [15:0] es = ref_sum(a_in, b_in, lane_nib, lane_byte);
    logic [15:0] em = ref_mask(lane_nib, lane_byte);
    total++;
    if (sum_out !== es) begin
      bad++;
      $display("FAIL %s sum a=%h b=%h nib=%b byte=%b actual=%h expected=%h",
               tag, a_in, b_in, lane_nib, lane_byte, sum_out, es);
    end
    total++;
    if (cut_mask !== em) begin
      bad++;
      $display("FAIL %s mask nib=%b byte=%b actual=%h expected=%h",
               tag, lane_nib, lane_byte, cut_mask, em);
    end
  endtask

  task automatic apply(input logic nb, by, input logic [15:0] a, b, input string tag);
    @(posedge clk); #1;
    lane_nib = nb; lane_byte = by; a_in = a; b_in = b;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string mode_tag(input logic nb, by);
    if (nb && by) return "R4";
    if (nb) return "R3 R7";
    if (by) return "R2 R6";
    return "R1 R5";
  endfunction

  initial begin
    logic [15:0] va [9] = '{16'h0000, 16'h1234, 16'hABCD, 16'hFFFF, 16'h0000,
                            16'hFFFF, 16'h0000, 16'h00FF, 16'h0FFF};
    logic [15:0] vb [9] = '{16'h0000, 16'h1234, 16'hABCD, 16'h0000, 16'h0000,
                            16'hFFFF, 16'hFFFF, 16'h0001, 16'h0111};
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("reset R1 R5");
    rst_n = 1'b1;

    apply(1'b0, 1'b0, 16'hFFFF, 16'h0001, "R1");
    apply(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R2");
    apply(1'b0, 1'b1, 16'h00FF, 16'h0001, "R2");
    apply(1'b1, 1'b0, 16'h0FFF, 16'h0111, "R3");
    apply(1'b1, 1'b1, 16'h0FFF, 16'h0111, "R4");

    for (int md = 0; md < 4; md++) begin
      logic nb = md[1];
      logic by = md[0];
      for (int k = 0; k < 9; k++) apply(nb, by, va[k], vb[k], mode_tag(nb, by));
      for (int k = 0; k < 250; k++)
        apply(nb, by, 16'($urandom), 16'($urandom), mode_tag(nb, by));
    end

    @(posedge clk); #1;
    lane_nib = 1'b0; lane_byte = 1'b1; a_in = 16'h80FF; b_in = 16'h8001;
    #1 compare("R8");
    lane_nib = 1'b1; lane_byte = 1'b0; a_in = 16'h7F8F; b_in = 16'h1111;
    #1 compare("R8");
    lane_nib = 1'b0; lane_byte = 1'b0; a_in = 16'h7FFF; b_in = 16'h0001;
    #1 compare("R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired before completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule